// File: doc/BRIEF.md
# Palette Entry Converter

This block turns a stream of 32-bit colour-table words into packed palette entries for an on-chip palette RAM. A one-cycle start pulse captures the active configuration: a 2-bit source encoding, a grayscale flag and a 3-bit output depth code. From then on every accepted stream word yields one converted entry. The entry goes out on a write port whose address starts at zero and rises by one per entry. When the entry at the last address is written, a one-cycle done flag is raised.

Each word is first expanded to 8-bit red, green and blue. If the source encoding has a transparency bit, that bit is kept. The colour is then packed at the chosen depth. A status output tells the fetch logic that the encoding selected now differs from the one used for the most recent load, so the table must be fetched and converted again. Memory fetch and the pixel pipeline sit outside this block.

Top module: `pal_convert`

## Requirements
- R1: After reset, wrEn, done and fmtStale are all 0, and no write appears until a start pulse has been given.
- R2: Encoding 0 (palFmt=0) reads red from bits 15:11, green from bits 10:5 and blue from bits 4:0. Each field is shifted to the top of its byte with zero fill, and output bit 24 is always 0.
- R3: Encodings 1, 2 and 3 copy input bit 24 into output bit 24 of the entry. Encoding 1 uses the same colour fields as encoding 0.
- R4: Encoding 2 reads red from bits 23:19, green from bits 15:10 and blue from bits 7:3. Each field stays at the top of its byte with zero fill.
- R5: Encoding 3 takes blue from bits 7:0, green from bits 15:8 and red from bits 23:16 unchanged.
- R6: When the grayscale flag is captured as 1, red, green and blue all equal input bits 7:0, under every encoding. The transparency rule of R2 and R3 still applies.
- R7: outDepth code 0 packs {r[7:5],g[7:5],b[7:6]} into bits 7:0. Code 1 packs 5:5:5 into bits 14:0 and code 2 packs 5:6:5 into bits 15:0, each from the top bits of the channels. Codes 3 to 7 give {r,g,b} in bits 23:0. Bits 31:25 are always 0, and any other bit not named is 0.
- R8: While loading, each cycle with inValid high writes one entry, one clock later, at an address that starts at 0 and rises by 1. Idle cycles write nothing.
- R9: done is high for exactly one cycle, together with the write to address ENTRIES-1. After that the block is idle and ignores stream words until the next start.
- R10: fmtStale is high exactly when at least one start has been seen and palFmt differs from the encoding captured at the most recent start.
- R11: A start pulse during a load restarts it at address 0 with the configuration then present. A word offered in the same cycle as start is not written.
- R12: Encoding, grayscale flag and depth are captured at start. Changing those inputs during a load does not change the entries of that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load and captures the configuration |
| inValid | input | 1 | Stream word on inData is offered this cycle |
| inData | input | 32 | Source palette word |
| palFmt | input | 2 | Source encoding, 0 to 3 |
| monoEn | input | 1 | Grayscale override |
| outDepth | input | 3 | Output depth code: 0=8, 1=15, 2=16, 3=24, 4 to 7=32 bits |
| wrEn | output | 1 | Palette RAM write strobe |
| wrAddr | output | $clog2(ENTRIES) | Palette RAM write address |
| wrData | output | 32 | Converted entry |
| done | output | 1 | Pulses with the final entry write |
| fmtStale | output | 1 | Selected encoding differs from the last captured one |

## Verification
The bench changes palFmt, monoEn and outDepth at random while loads are running. A design that decoded from live inputs instead of the captured configuration would write entries mixing two encodings. Stream gaps and a start given partway through a load check the address sequence: an off-by-one counter, or one that fails to clear on restart, shows up as a wrong wrAddr or a done flag at the wrong entry. Grayscale under encoding 0, words with bit 24 set, and depth codes above 4 catch leaked transparency bits, swapped bit slices and unmapped depth codes. Words offered after done check that a finished load stays closed.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int ALPHA_POS = 24;

  typedef enum logic [2:0] {
    DEPTH8  = 3'd0,
    DEPTH15 = 3'd1,
    DEPTH16 = 3'd2,
    DEPTH24 = 3'd3,
    DEPTH32 = 3'd4
  } depth_e;

  typedef enum logic [1:0] {
    SRC565   = 2'd0,
    SRC565T  = 2'd1,
    SRC666T  = 2'd2,
    SRC888T  = 2'd3
  } srcfmt_e;

  typedef struct packed {
    logic capture;
    logic accept;
    logic last;
  } ctrl_strobe_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  output ctrl_strobe_t      strobe,
  output logic [ADDR_W-1:0] idx,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(ENTRIES - 1);

  logic busy;

  always_comb begin
    strobe.capture = start;
    strobe.accept  = inValid && busy && !start;
    strobe.last    = strobe.accept && (idx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= strobe.last;
      if (strobe.capture) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (strobe.accept) begin
        idx <= idx + 1'b1;
        if (strobe.last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] idx,
  input  logic [31:0]       inData,
  input  logic [1:0]        palFmt,
  input  logic              monoEn,
  input  logic [2:0]        outDepth,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              fmtStale
);
  srcfmt_e     cfgFmt;
  logic        cfgMono;
  depth_e      cfgDepth;
  logic        seenStart;
  logic [7:0]  red, grn, blu;
  logic [31:0] packed_px;
  logic        alphaBit;
  logic [31:0] entry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFmt    <= SRC565;
      cfgMono   <= 1'b0;
      cfgDepth  <= DEPTH8;
      seenStart <= 1'b0;
    end else if (strobe.capture) begin
      cfgFmt    <= srcfmt_e'(palFmt);
      cfgMono   <= monoEn;
      cfgDepth  <= depth_e'(outDepth);
      seenStart <= 1'b1;
    end
  end

  assign fmtStale = seenStart && (palFmt != cfgFmt);

  // channel extraction
  always_comb begin
    if (cfgMono) begin
      red = inData[7:0];
      grn = inData[7:0];
      blu = inData[7:0];
    end else begin
      unique case (cfgFmt)
        SRC666T: begin
          red = {inData[23:19], 3'b000};
          grn = {inData[15:10], 2'b00};
          blu = {inData[7:3], 3'b000};
        end
        SRC888T: begin
          red = inData[23:16];
          grn = inData[15:8];
          blu = inData[7:0];
        end
        default: begin
          red = {inData[15:11], 3'b000};
          grn = {inData[10:5], 2'b00};
          blu = {inData[4:0], 3'b000};
        end
      endcase
    end
    alphaBit = (cfgFmt != SRC565) && inData[ALPHA_POS];
  end

  // depth packing
  always_comb begin
    case (cfgDepth)
      DEPTH8:  packed_px = {24'd0, red[7:5], grn[7:5], blu[7:6]};
      DEPTH15: packed_px = {17'd0, red[7:3], grn[7:3], blu[7:3]};
      DEPTH16: packed_px = {16'd0, red[7:3], grn[7:2], blu[7:3]};
      default: packed_px = {8'd0, red, grn, blu};
    endcase
    entry = packed_px;
    entry[ALPHA_POS] = packed_px[ALPHA_POS] | alphaBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strobe.accept;
      if (strobe.accept) begin
        wrAddr <= idx;
        wrData <= entry;
      end
    end
  end
endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [31:0]       inData,
  input  logic [1:0]        palFmt,
  input  logic              monoEn,
  input  logic [2:0]        outDepth,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              done,
  output logic              fmtStale
);
  ctrl_strobe_t      strobe;
  logic [ADDR_W-1:0] idx;

  pal_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .strobe(strobe), .idx(idx), .done(done)
  );

  pal_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx),
    .inData(inData), .palFmt(palFmt), .monoEn(monoEn), .outDepth(outDepth),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .fmtStale(fmtStale)
  );
endmodule

// File: rtl/pal_convert_chk.sv
module pal_convert_chk #(
  parameter int ENTRIES = 256,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              inValid,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              done
);
  // R9
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wrEn && wrAddr == ADDR_W'(ENTRIES - 1)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData[31:25] == 7'd0));
  // R8
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($past(inValid) && !$past(start)));
  // R11
  start_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !wrEn);
endmodule

bind pal_convert pal_convert_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done)
);

// File: tb/pal_convert_tb.sv
module pal_convert_tb;
  localparam int N = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          inValid = 1'b0;
  logic [31:0]   inData = '0;
  logic [1:0]    palFmt = '0;
  logic          monoEn = 1'b0;
  logic [2:0]    outDepth = '0;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [31:0]   wrData;
  logic          done;
  logic          fmtStale;

  int checks = 0;
  int fails = 0;

  // bench model state
  int          expIdx = 0;
  bit          mBusy = 0;
  int          cFmt = 0, cMono = 0, cDep = 0;
  bit          pend = 0;
  int          pAddr = 0;
  logic [31:0] pData = '0;
  bit          pLast = 0;
  string       addrTag = "R8";

  always #2 clk = ~clk;

  pal_convert #(.ENTRIES(N)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .palFmt(palFmt), .monoEn(monoEn), .outDepth(outDepth),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done), .fmtStale(fmtStale)
  );

  function automatic logic [31:0] expConv(int f, int m, int dp, logic [31:0] d);
    int r, g, b;
    logic [31:0] px;
    if (m != 0) begin
      r = int'(d & 32'hff); g = r; b = r;
    end else if (f == 3) begin
      r = int'((d >> 16) & 32'hff); g = int'((d >> 8) & 32'hff); b = int'(d & 32'hff);
    end else if (f == 2) begin
      r = int'((d >> 16) & 32'hf8); g = int'((d >> 8) & 32'hfc); b = int'(d & 32'hf8);
    end else begin
      r = int'((d >> 8) & 32'hf8); g = int'((d >> 3) & 32'hfc); b = int'((d << 3) & 32'hf8);
    end
    case (dp)
      0: px = 32'(((r >> 5) << 5) | ((g >> 5) << 2) | (b >> 6));
      1: px = 32'(((r >> 3) << 10) | ((g >> 3) << 5) | (b >> 3));
      2: px = 32'(((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3));
      default: px = 32'((r << 16) | (g << 8) | b);
    endcase
    if (f != 0) px = px | (d & 32'h0100_0000);
    return px;
  endfunction

  function automatic string fmtTag(int f, int m);
    if (m != 0) return "R6";
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic checkOut();
    checks++;
    if (pend) begin
      if (!wrEn || wrAddr != AW'(pAddr)) begin
        fails++;
        $display("FAIL %s write/addr: wrEn=%0d addr=%0d expected wrEn=1 addr=%0d",
                 addrTag, wrEn, wrAddr, pAddr);
      end
      checks++;
      if (wrData !== pData) begin
        fails++;
        $display("FAIL %s R7 R12 data: got %h expected %h (fmt %0d mono %0d depth %0d)",
                 fmtTag(cFmt, cMono), wrData, pData, cFmt, cMono, cDep);
      end
      checks++;
      if (done !== pLast) begin
        fails++;
        $display("FAIL R9 done: got %0d expected %0d", done, pLast);
      end
    end else if (wrEn !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R8 R9 idle: wrEn=%0d done=%0d expected 0 0", wrEn, done);
    end
  endtask

  task automatic tick(bit st, bit v, logic [31:0] d, int f, int m, int dp);
    @(negedge clk);
    checkOut();
    start = st; inValid = v; inData = d;
    palFmt = 2'(f); monoEn = m[0]; outDepth = 3'(dp);
    pend = 0;
    if (st) begin
      expIdx = 0; mBusy = 1; cFmt = f; cMono = m; cDep = dp;
    end else if (v && mBusy) begin
      pend = 1; pAddr = expIdx; pData = expConv(cFmt, cMono, cDep, d);
      pLast = (expIdx == N - 1);
      expIdx++;
      if (pLast) mBusy = 0;
    end
  endtask

  // full load; configuration inputs scrambled during the load (R12)
  task automatic runLoad(int f, int m, int dp, bit directed, logic [31:0] base);
    int cnt = 0;
    tick(1, 0, 0, f, m, dp);
    while (cnt < N) begin
      bit v = directed ? 1'b1 : ($urandom % 4 != 0);
      logic [31:0] d = directed ? (base ^ (32'(cnt) * 32'h0101_0101)) : $urandom;
      tick(0, v, d, int'($urandom % 4), int'($urandom % 2), int'($urandom % 8));
      if (v) cnt++;
    end
    tick(0, 0, 0, f, m, dp);
    // words after done must be ignored (R9)
    tick(0, 1, $urandom, f, m, dp);
    tick(0, 0, 0, f, m, dp);
  endtask

  task automatic staleCheck(int f, bit exp);
    tick(0, 0, 0, f, cMono, cDep);
    #1;
    checks++;
    if (fmtStale !== exp) begin
      fails++;
      $display("FAIL R10 fmtStale: got %0d expected %0d (palFmt %0d)", fmtStale, exp, f);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (wrEn !== 0 || done !== 0 || fmtStale !== 0) begin
      fails++;
      $display("FAIL R1 reset: wrEn=%0d done=%0d fmtStale=%0d expected 0 0 0",
               wrEn, done, fmtStale);
    end
    // words before any start (R1)
    tick(0, 1, 32'hdead_beef, 0, 0, 0);
    tick(0, 1, 32'h0123_4567, 1, 0, 0);
    tick(0, 0, 0, 0, 0, 0);

    // directed corners
    runLoad(3, 0, 0, 1, 32'hffff_ffff);
    runLoad(0, 1, 4, 1, 32'h01ff_ffa5);
    runLoad(1, 1, 3, 1, 32'h0100_00c3);
    runLoad(2, 0, 7, 1, 32'h01f8_fcf8);

    // sweep of all encodings, grayscale and depths with random data
    for (int f = 0; f < 4; f++)
      for (int m = 0; m < 2; m++)
        for (int dp = 0; dp < 8; dp++)
          runLoad(f, m, dp, 0, 0);

    // R10 stale format indication
    runLoad(2, 0, 1, 0, 0);
    staleCheck(2, 0);
    staleCheck(3, 1);
    staleCheck(0, 1);
    staleCheck(2, 0);

    // R11 restart in the middle of a load
    addrTag = "R11";
    tick(1, 0, 0, 3, 0, 2);
    for (int i = 0; i < 5; i++) tick(0, 1, $urandom, 3, 0, 2);
    runLoad(1, 0, 0, 0, 0);
    tick(1, 0, 0, 2, 1, 1);
    for (int i = 0; i < 3; i++) tick(0, 1, $urandom, 2, 1, 1);
    tick(1, 1, 32'h00ab_cdef, 0, 0, 4);
    for (int i = 0; i < N; i++) tick(0, 1, $urandom, 1, 1, 0);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    staleCheck(0, 0);
    addrTag = "R8";

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule